// File: doc/BRIEF.md
# Dual-Port Instruction Cache with Shared Refill

This block is an instruction cache for a fetch unit that issues two instructions per cycle. It gives each instruction stream its own lookup port. Each port compares its own tag and returns its word in the same cycle whenever the line is present. The cache is direct-mapped. Each line holds a power-of-two number of words, and every valid bit is cleared by reset.

There is only one channel to backing memory. One refill controller serves the misses of both ports, one line at a time. A port that misses keeps its request and address steady and sees `valid` low until its line has arrived. A hit on the other port is answered at once, even while the refill is in progress. If both ports miss in the same cycle, port 0 is served first. Port 1 is then looked up again, so it hits without further traffic when it wanted the same line.

Each refill goes through four steps:
1. The victim line is invalidated for one cycle.
2. The words of the line are fetched in ascending order, one handshake per word.
3. The tag is written and the line is marked valid.
4. The controller returns to idle.

Top module: `dual_fetch_icache`

## Requirements
- R1: After reset, no line is valid. A first request on either port gives `valid` low and starts a refill.
- R2: A port whose address hits sees `valid` high in the same cycle, with the stored word for that address. Each port does this independently.
- R3: A refill fetches every word of the line. Offsets run from 0 upward over `mem_addr_o`, and one word is taken on each cycle in which `mem_req_o` and `mem_ready_i` are both high.
- R4: While `mem_req_o` is high and `mem_ready_i` is low, `mem_addr_o` holds its value and `mem_req_o` stays high.
- R5: A missing port sees `valid` high with the fetched word once its refill completes.
- R6: When both ports miss in the same cycle, the first refill address is port 0's line.
- R7: When both ports miss on the same line, exactly one line of words is fetched and both ports then hit.
- R8: A hit on one port is reported while a refill for the other port is in progress.
- R9: The cache is direct-mapped. The index is the address bits just above the offset, and the tag is the bits above the index. Filling a line evicts the older line at that index, so the older line's address misses afterwards.
- R10: A port with its request low shows `valid` low and starts no refill.
- R11: No port reports a hit on the line currently being filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p0_req_i | input | 1 | Port 0 lookup request |
| p0_addr_i | input | ADDR_W | Port 0 word address |
| p0_instr_o | output | DATA_W | Port 0 instruction word |
| p0_valid_o | output | 1 | Port 0 hit, word valid |
| p1_req_i | input | 1 | Port 1 lookup request |
| p1_addr_i | input | ADDR_W | Port 1 word address |
| p1_instr_o | output | DATA_W | Port 1 instruction word |
| p1_valid_o | output | 1 | Port 1 hit, word valid |
| mem_req_o | output | 1 | Memory word request |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_data_i | input | DATA_W | Memory read data |
| mem_ready_i | input | 1 | Memory data valid, word accepted |

## Verification
The bench builds the cache with ADDR_W=12, LINES=8, WORDS=4 and DATA_W=32. With these values, short hand-picked addresses land on the same index with different tags. This brings eviction and the fill-line blocking rule within reach in a few cycles. The memory model inserts a wait cycle between words, so the address-hold rule is exercised on every refill. A scoreboard queue holds the expected refill address sequence. It catches ordering errors between the two ports and any surplus fetches.

// File: rtl/dfic_pkg.sv
package dfic_pkg;
  typedef enum logic [1:0] {
    RF_IDLE,
    RF_REQUEST,
    RF_FILL,
    RF_UPDATE
  } rf_state_e;

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/dfic_tag_store.sv
module dfic_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 10,
  parameter int NP    = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0][IDX_W-1:0]  rd_idx_i,
  input  logic [NP-1:0][TAG_W-1:0]  rd_tag_i,
  output logic [NP-1:0]             hit_o,
  input  logic                      clr_i,
  input  logic                      set_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [TAG_W-1:0]          wr_tag_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (clr_i) begin
      valid_q[wr_idx_i] <= 1'b0;
    end else if (set_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (set_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  for (genvar g = 0; g < NP; g++) begin : g_cmp
    assign hit_o[g] = valid_q[rd_idx_i[g]] && (tag_q[rd_idx_i[g]] == rd_tag_i[g]);
  end
endmodule

// File: rtl/dfic_data_store.sv
module dfic_data_store #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int NP     = 2,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int ENT   = LINES * WORDS
) (
  input  logic                      clk_i,
  input  logic [NP-1:0][IDX_W-1:0]  rd_idx_i,
  input  logic [NP-1:0][OFF_W-1:0]  rd_off_i,
  output logic [NP-1:0][DATA_W-1:0] rd_data_o,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [OFF_W-1:0]          wr_off_i,
  input  logic [DATA_W-1:0]         wr_data_i
);
  logic [DATA_W-1:0] word_q [ENT];

  always_ff @(posedge clk_i) begin
    if (we_i) word_q[{wr_idx_i, wr_off_i}] <= wr_data_i;
  end

  for (genvar g = 0; g < NP; g++) begin : g_rd
    assign rd_data_o[g] = word_q[{rd_idx_i[g], rd_off_i[g]}];
  end
endmodule

// File: rtl/dfic_refill_ctrl.sv
module dfic_refill_ctrl
  import dfic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4,
  parameter int NP     = 2,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0]             miss_i,
  input  logic [NP-1:0][LINE_W-1:0] line_i,
  input  logic                      mem_ready_i,
  output logic                      mem_req_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic                      inval_o,
  output logic                      commit_o,
  output logic                      word_we_o,
  output logic [LINE_W-1:0]         fill_line_o,
  output logic [OFF_W-1:0]          fill_off_o
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  rf_state_e         state_q, state_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    line_d  = line_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      RF_IDLE: begin
        // lowest port number wins
        for (int p = NP - 1; p >= 0; p--) begin
          if (miss_i[p]) begin
            line_d  = line_i[p];
            state_d = RF_REQUEST;
          end
        end
      end
      RF_REQUEST: begin
        cnt_d   = '0;
        state_d = RF_FILL;
      end
      RF_FILL: begin
        if (mem_ready_i) begin
          if (cnt_q == LAST_OFF) state_d = RF_UPDATE;
          else                   cnt_d   = cnt_q + 1'b1;
        end
      end
      RF_UPDATE: state_d = RF_IDLE;
      default:   state_d = RF_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      line_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      line_q  <= line_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mem_req_o   = (state_q == RF_FILL);
  assign mem_addr_o  = {line_q, cnt_q};
  assign inval_o     = (state_q == RF_REQUEST);
  assign commit_o    = (state_q == RF_UPDATE);
  assign word_we_o   = mem_req_o && mem_ready_i;
  assign fill_line_o = line_q;
  assign fill_off_o  = cnt_q;
endmodule

// File: rtl/dual_fetch_icache.sv
module dual_fetch_icache
  import dfic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              p0_req_i,
  input  logic [ADDR_W-1:0] p0_addr_i,
  output logic [DATA_W-1:0] p0_instr_o,
  output logic              p0_valid_o,
  input  logic              p1_req_i,
  input  logic [ADDR_W-1:0] p1_addr_i,
  output logic [DATA_W-1:0] p1_instr_o,
  output logic              p1_valid_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              mem_ready_i
);
  localparam int NP     = NUM_PORTS;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [NP-1:0]             req, hit, miss, valid;
  logic [NP-1:0][ADDR_W-1:0] addr;
  logic [NP-1:0][IDX_W-1:0]  rd_idx;
  logic [NP-1:0][TAG_W-1:0]  rd_tag;
  logic [NP-1:0][OFF_W-1:0]  rd_off;
  logic [NP-1:0][LINE_W-1:0] rd_line;
  logic [NP-1:0][DATA_W-1:0] rd_data;

  logic              inval, commit, word_we;
  logic [LINE_W-1:0] fill_line;
  logic [OFF_W-1:0]  fill_off;

  assign req     = {p1_req_i, p0_req_i};
  assign addr[0] = p0_addr_i;
  assign addr[1] = p1_addr_i;

  for (genvar g = 0; g < NP; g++) begin : g_port
    assign rd_off[g]  = addr[g][OFF_W-1:0];
    assign rd_idx[g]  = addr[g][OFF_W+:IDX_W];
    assign rd_tag[g]  = addr[g][ADDR_W-1-:TAG_W];
    assign rd_line[g] = addr[g][ADDR_W-1:OFF_W];
    assign miss[g]    = req[g] && !hit[g];
    assign valid[g]   = req[g] && hit[g];
  end

  assign p0_valid_o = valid[0];
  assign p1_valid_o = valid[1];
  assign p0_instr_o = valid[0] ? rd_data[0] : '0;
  assign p1_instr_o = valid[1] ? rd_data[1] : '0;

  dfic_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .NP(NP)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_tag_i (rd_tag),
    .hit_o    (hit),
    .clr_i    (inval),
    .set_i    (commit),
    .wr_idx_i (fill_line[IDX_W-1:0]),
    .wr_tag_i (fill_line[LINE_W-1:IDX_W])
  );

  dfic_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .NP(NP)) u_data (
    .clk_i     (clk_i),
    .rd_idx_i  (rd_idx),
    .rd_off_i  (rd_off),
    .rd_data_o (rd_data),
    .we_i      (word_we),
    .wr_idx_i  (fill_line[IDX_W-1:0]),
    .wr_off_i  (fill_off),
    .wr_data_i (mem_data_i)
  );

  dfic_refill_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .NP(NP)) u_refill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_i      (miss),
    .line_i      (rd_line),
    .mem_ready_i (mem_ready_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .inval_o     (inval),
    .commit_o    (commit),
    .word_we_o   (word_we),
    .fill_line_o (fill_line),
    .fill_off_o  (fill_off)
  );
endmodule

// File: rtl/dfic_chk.sv
module dfic_chk #(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              p0_req_i,
  input logic [ADDR_W-1:0] p0_addr_i,
  input logic              p0_valid_o,
  input logic              p1_req_i,
  input logic [ADDR_W-1:0] p1_addr_i,
  input logic              p1_valid_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && mem_addr_o[OFF_W-1:0] != LAST_OFF)
      |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

  // R3
  fill_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o[OFF_W-1:0] == '0));

  // R10
  p0_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p0_req_i |-> !p0_valid_o);

  // R10
  p1_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p1_req_i |-> !p1_valid_o);

  // R11
  p0_fill_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_valid_o && mem_req_o) |-> (p0_addr_i[ADDR_W-1:OFF_W] != mem_addr_o[ADDR_W-1:OFF_W]));

  // R11
  p1_fill_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_valid_o && mem_req_o) |-> (p1_addr_i[ADDR_W-1:OFF_W] != mem_addr_o[ADDR_W-1:OFF_W]));
endmodule

bind dual_fetch_icache dfic_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (.*);

// File: tb/tb_dual_fetch_icache.sv
module tb_dual_fetch_icache;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int LINES  = 8;
  localparam int WORDS  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              p0_req = 1'b0, p1_req = 1'b0;
  logic [ADDR_W-1:0] p0_addr = '0, p1_addr = '0;
  logic [DATA_W-1:0] p0_instr, p1_instr;
  logic              p0_valid, p1_valid;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data = '0;
  logic              mem_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  int hs_cnt = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] exp_q [$];

  always #10 clk = ~clk;

  dual_fetch_icache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .p0_req_i(p0_req), .p0_addr_i(p0_addr), .p0_instr_o(p0_instr), .p0_valid_o(p0_valid),
    .p1_req_i(p1_req), .p1_addr_i(p1_addr), .p1_instr_o(p1_instr), .p1_valid_o(p1_valid),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_i(mem_data), .mem_ready_i(mem_ready)
  );

  function automatic logic [DATA_W-1:0] memfn(input logic [ADDR_W-1:0] a);
    return {8'hA5, ~a, a};
  endfunction

  task automatic chk(input string r, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic push_line(input logic [ADDR_W-1:0] base);
    for (int i = 0; i < WORDS; i++) exp_q.push_back(base + ADDR_W'(i));
  endtask

  task automatic wait_port(input int port, input logic [ADDR_W-1:0] a, input string r);
    bit got = 1'b0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk);
      #3;
      got = (port == 0) ? p0_valid : p1_valid;
    end
    chk(r, got, 32'(got), 32'd1);
    if (port == 0) chk(r, p0_instr == memfn(a), p0_instr, memfn(a));
    else           chk(r, p1_instr == memfn(a), p1_instr, memfn(a));
  endtask

  task automatic wait_fill();
    for (int i = 0; i < 20 && !mem_req; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  // memory model: one wait cycle between words
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        mem_ready = ~mem_ready;
        mem_data  = memfn(mem_addr);
      end else begin
        mem_ready = 1'b0;
      end
    end
  end

  // monitor: compares each accepted memory address with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && mem_req && mem_ready) begin
        hs_cnt++;
        if (exp_q.size() == 0) begin
          chk("R3 R7 unexpected fetch", 1'b0, 32'(mem_addr), 32'hFFFF_FFFF);
        end else begin
          logic [ADDR_W-1:0] e;
          e = exp_q.pop_front();
          chk("R3 R6 refill order", mem_addr == e, 32'(mem_addr), 32'(e));
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (!done && cycles > 20000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk("R1 reset p0", !p0_valid, 32'(p0_valid), 0);
    chk("R1 reset mem_req", !mem_req, 32'(mem_req), 0);

    // R10: request low, miss address, no refill
    step();
    p1_addr = 12'h013;
    repeat (4) step();
    #1;
    chk("R10 no req valid", !p1_valid, 32'(p1_valid), 0);
    chk("R10 no refill", hs_cnt == 0 && !mem_req, 32'(hs_cnt), 0);

    // R1 R5: cold miss
    push_line(12'h010);
    p0_addr = 12'h013;
    p0_req  = 1'b1;
    #1;
    chk("R1 cold miss", !p0_valid, 32'(p0_valid), 0);
    wait_port(0, 12'h013, "R5 fill then hit");
    chk("R3 whole line fetched", exp_q.size() == 0, 32'(exp_q.size()), 0);
    step();
    p0_req = 1'b0;

    // R2: hits on both ports in the same cycle
    step();
    p0_addr = 12'h011; p0_req = 1'b1;
    p1_addr = 12'h012; p1_req = 1'b1;
    #2;
    chk("R2 p0 hit", p0_valid && p0_instr == memfn(12'h011), p0_instr, memfn(12'h011));
    chk("R2 p1 hit", p1_valid && p1_instr == memfn(12'h012), p1_instr, memfn(12'h012));
    step();
    p0_req = 1'b0; p1_req = 1'b0;

    // R6: simultaneous misses on different lines
    step();
    push_line(12'h040);
    push_line(12'h044);
    p0_addr = 12'h040; p0_req = 1'b1;
    p1_addr = 12'h045; p1_req = 1'b1;
    wait_port(0, 12'h040, "R6 p0 served");
    wait_port(1, 12'h045, "R6 p1 served");
    chk("R6 queue drained", exp_q.size() == 0, 32'(exp_q.size()), 0);
    step();
    p0_req = 1'b0; p1_req = 1'b0;

    // R7: simultaneous misses on the same line
    step();
    h0 = hs_cnt;
    push_line(12'h080);
    p0_addr = 12'h082; p0_req = 1'b1;
    p1_addr = 12'h081; p1_req = 1'b1;
    wait_port(0, 12'h082, "R7 p0");
    wait_port(1, 12'h081, "R7 p1");
    repeat (4) step();
    chk("R7 single line fetch", hs_cnt - h0 == WORDS, 32'(hs_cnt - h0), 32'(WORDS));
    p0_req = 1'b0; p1_req = 1'b0;

    // R8: hit on p1 during p0 refill
    step();
    push_line(12'h100);
    p0_addr = 12'h100; p0_req = 1'b1;
    wait_fill();
    p1_addr = 12'h012; p1_req = 1'b1;
    #1;
    chk("R8 hit during refill", mem_req && p1_valid && p1_instr == memfn(12'h012),
        {mem_req, p1_valid, p1_instr[29:0]}, {2'b11, memfn(12'h012)[29:0]});
    step();
    p1_req = 1'b0;
    wait_port(0, 12'h100, "R5 p0 after R8");
    step();
    p0_req = 1'b0;

    // R11 R9: p0 fills index 4 with another tag while p1 wants the old line
    step();
    push_line(12'h0B0);
    push_line(12'h010);
    p0_addr = 12'h0B0; p0_req = 1'b1;
    wait_fill();
    p1_addr = 12'h013; p1_req = 1'b1;
    #1;
    chk("R11 old line blocked during fill", !p1_valid, 32'(p1_valid), 0);
    wait_port(0, 12'h0B0, "R9 new line hit");
    step();
    p0_req = 1'b0;
    wait_port(1, 12'h013, "R9 old line refilled");
    step();
    p1_req = 1'b0;
    push_line(12'h0B0);
    p0_addr = 12'h0B0; p0_req = 1'b1;
    #1;
    chk("R9 evicted line misses", !p0_valid, 32'(p0_valid), 0);
    wait_port(0, 12'h0B0, "R9 refetch");
    step();
    p0_req = 1'b0;

    // R10: cached address with request low
    repeat (3) step();
    chk("R10 cached no req", !p0_valid && !mem_req, {p0_valid, mem_req}, 0);
    chk("R3 scoreboard empty", exp_q.size() == 0, 32'(exp_q.size()), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule